// File: doc/BRIEF.md
# Single-Transfer Bus Master Engine

This block turns a one-shot command into one classic single read or single write cycle on a synchronous SoC bus. A command port supplies an address, write data, a byte-lane mask and a direction, then raises a start pulse. The engine drives the bus outputs for that request, including the cycle-active flag, the strobe, the address, the data, the lane mask and the write flag.

The slave may stretch the cycle for any number of clocks by holding its acknowledge low. On the clock edge where acknowledge is seen high, a read captures the slave's data. The cycle then closes, and the command port gets a one-clock done pulse. While a cycle is open, a busy flag tells the command port not to issue another request. Any start pulse that arrives during that time is dropped.

Reset is synchronous. It takes effect at the first rising edge where it is sampled high, and it holds every bus output idle until the next edge after it is released. It aborts a cycle that is in flight.

Top module: `bus_single_master`

## Requirements
- R1: At every rising edge where `rst` is high, the outputs become idle: `m_active`, `m_strobe`, `m_write`, `cmd_busy` and `rsp_done` are 0, `m_sel` is 0 and `rsp_rdata` is 0. Outputs stay idle at the first edge after release unless that edge accepts a start.
- R2: At an edge where the engine is idle, `rst` is low and `cmd_start` is 1, the command is accepted. From the next cycle, `m_active`, `m_strobe` and `cmd_busy` are 1. `m_addr`, `m_wdata` and `m_sel` equal the command values, and `m_write` equals `cmd_write` (1 = write, 0 = read).
- R3: While the cycle is open and `s_ack` is sampled 0, the next cycle keeps `m_active` and `m_strobe` at 1, and `m_addr`, `m_wdata`, `m_sel` and `m_write` unchanged. The number of wait states is unbounded.
- R4: At the edge where `s_ack` is sampled 1 during an open cycle, the next cycle has `m_active`, `m_strobe`, `m_write` and `cmd_busy` at 0, `m_sel` at 0, and `rsp_done` at 1. `rsp_done` lasts exactly one cycle.
- R5: For a read cycle, `rsp_rdata` takes the value of `s_rdata` sampled at the acknowledging edge. It holds that value until the next read completes or until reset.
- R6: A write cycle leaves `rsp_rdata` unchanged.
- R7: A `cmd_start` while `cmd_busy` is 1 is ignored. It does not change the bus outputs, and no second cycle follows the done pulse.
- R8: Reset during an open cycle ends it at the next edge, with no done pulse.
- R9: `s_ack` while the engine is idle has no effect: no done pulse and no cycle starts.
- R10: `m_sel` has one bit per byte lane, DATA_W/8 bits (4 for the 32-bit default). Bit i is passed unchanged from `cmd_sel` bit i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_start | input | 1 | Request pulse from the command port |
| cmd_write | input | 1 | Direction: 1 write, 0 read |
| cmd_addr | input | ADDR_W | Target address |
| cmd_wdata | input | DATA_W | Data to write |
| cmd_sel | input | DATA_W/8 | Byte-lane mask |
| cmd_busy | output | 1 | Cycle in progress, do not start |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | DATA_W | Data returned by the last read |
| m_active | output | 1 | Bus cycle in progress |
| m_strobe | output | 1 | Transfer strobe |
| m_write | output | 1 | Write enable |
| m_addr | output | ADDR_W | Bus address |
| m_wdata | output | DATA_W | Bus write data |
| m_sel | output | DATA_W/8 | Bus byte-lane mask |
| s_ack | input | 1 | Slave acknowledge |
| s_rdata | input | DATA_W | Slave read data |

## Verification
The assertions check the following on every cycle:
- reset forces the outputs idle;
- an open cycle that is not acknowledged keeps its outputs frozen, and busy-time start pulses cannot disturb them;
- an acknowledge closes the cycle on the following edge;
- the done pulse follows an acknowledge and lasts one cycle.

Only the bench scenarios show that the captured read data matches what the slave offered and survives later writes. They also show that the mask lanes and the direction arrive intact, that a reset in mid-cycle leaves no done pulse, and that a stray acknowledge while idle is harmless.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_OPEN = 1'b1
    } sbm_state_e;
endpackage

// File: rtl/sbm_ctrl.sv
module sbm_ctrl
    import sbm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic ack,
    output logic open_cyc,
    output logic fire,
    output logic finish,
    output logic done
);
    typedef struct packed {
        sbm_state_e st;
        logic       done;
    } ctrl_s;

    ctrl_s ctrl_d, ctrl_q;

    always_comb begin
        fire   = (ctrl_q.st == ST_IDLE) && start;
        finish = (ctrl_q.st == ST_OPEN) && ack;
        ctrl_d      = ctrl_q;
        ctrl_d.done = 1'b0;
        case (ctrl_q.st)
            ST_IDLE: if (fire)   ctrl_d.st = ST_OPEN;
            ST_OPEN: if (finish) begin
                ctrl_d.st   = ST_IDLE;
                ctrl_d.done = 1'b1;
            end
            default: ctrl_d.st = ST_IDLE;
        endcase
        if (rst) begin
            ctrl_d.st   = ST_IDLE;
            ctrl_d.done = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        ctrl_q <= ctrl_d;
    end

    assign open_cyc = (ctrl_q.st == ST_OPEN);
    assign done     = ctrl_q.done;
endmodule

// File: rtl/sbm_req.sv
module sbm_req #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int SEL_W  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic              finish,
    input  logic              in_write,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_wdata,
    input  logic [SEL_W-1:0]  in_sel,
    output logic              out_write,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_wdata,
    output logic [SEL_W-1:0]  out_sel
);
    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [SEL_W-1:0]  sel;
    } req_s;

    req_s req_d, req_q;

    always_comb begin
        req_d = req_q;
        if (fire) begin
            req_d.wr    = in_write;
            req_d.addr  = in_addr;
            req_d.wdata = in_wdata;
        end else if (finish) begin
            req_d.wr = 1'b0;
        end
        // lane mask copied bit by bit so lane i maps to lane i
        for (int i = 0; i < SEL_W; i++) begin
            if (fire)        req_d.sel[i] = in_sel[i];
            else if (finish) req_d.sel[i] = 1'b0;
        end
        if (rst) begin
            req_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        req_q <= req_d;
    end

    assign out_write = req_q.wr;
    assign out_addr  = req_q.addr;
    assign out_wdata = req_q.wdata;
    assign out_sel   = req_q.sel;
endmodule

// File: rtl/sbm_rsp.sv
module sbm_rsp #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              finish,
    input  logic              is_write,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] rdata
);
    typedef struct packed {
        logic [DATA_W-1:0] rd;
    } rsp_s;

    rsp_s rsp_d, rsp_q;

    always_comb begin
        rsp_d = rsp_q;
        if (finish && !is_write) rsp_d.rd = bus_rdata;
        if (rst)                 rsp_d = '0;
    end

    always_ff @(posedge clk) begin
        rsp_q <= rsp_d;
    end

    assign rdata = rsp_q.rd;
endmodule

// File: rtl/bus_single_master.sv
module bus_single_master #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cmd_start,
    input  logic                  cmd_write,
    input  logic [ADDR_W-1:0]     cmd_addr,
    input  logic [DATA_W-1:0]     cmd_wdata,
    input  logic [DATA_W/8-1:0]   cmd_sel,
    output logic                  cmd_busy,
    output logic                  rsp_done,
    output logic [DATA_W-1:0]     rsp_rdata,
    output logic                  m_active,
    output logic                  m_strobe,
    output logic                  m_write,
    output logic [ADDR_W-1:0]     m_addr,
    output logic [DATA_W-1:0]     m_wdata,
    output logic [DATA_W/8-1:0]   m_sel,
    input  logic                  s_ack,
    input  logic [DATA_W-1:0]     s_rdata
);
    localparam int SEL_W = DATA_W / 8;

    logic open_cyc;
    logic fire;
    logic finish;

    sbm_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (cmd_start),
        .ack      (s_ack),
        .open_cyc (open_cyc),
        .fire     (fire),
        .finish   (finish),
        .done     (rsp_done)
    );

    sbm_req #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .SEL_W  (SEL_W)
    ) u_req (
        .clk       (clk),
        .rst       (rst),
        .fire      (fire),
        .finish    (finish),
        .in_write  (cmd_write),
        .in_addr   (cmd_addr),
        .in_wdata  (cmd_wdata),
        .in_sel    (cmd_sel),
        .out_write (m_write),
        .out_addr  (m_addr),
        .out_wdata (m_wdata),
        .out_sel   (m_sel)
    );

    sbm_rsp #(
        .DATA_W (DATA_W)
    ) u_rsp (
        .clk       (clk),
        .rst       (rst),
        .finish    (finish),
        .is_write  (m_write),
        .bus_rdata (s_rdata),
        .rdata     (rsp_rdata)
    );

    assign m_active = open_cyc;
    assign m_strobe = open_cyc;
    assign cmd_busy = open_cyc;
endmodule

// File: rtl/sbm_chk.sv
module sbm_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic                clk,
    input logic                rst,
    input logic                cmd_start,
    input logic                rsp_done,
    input logic                m_active,
    input logic                m_strobe,
    input logic                m_write,
    input logic [ADDR_W-1:0]   m_addr,
    input logic [DATA_W-1:0]   m_wdata,
    input logic [DATA_W/8-1:0] m_sel,
    input logic                s_ack
);
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!m_active && !m_strobe && !m_write && !rsp_done && m_sel == '0));

    // R3
    wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (m_active && !s_ack) |=> (m_active && m_strobe && $stable(m_addr)
                                  && $stable(m_wdata) && $stable(m_sel) && $stable(m_write)));

    // R4
    ack_close_chk: assert property (@(posedge clk) disable iff (rst)
        (m_active && s_ack) |=> (!m_active && !m_strobe && !m_write && rsp_done));

    // R4
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);

    // R9
    done_cause_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> $past(m_active && s_ack));

    // R7
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        (m_active && !s_ack && cmd_start) |=> $stable(m_addr));
endmodule

bind bus_single_master sbm_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_sbm_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_start (cmd_start),
    .rsp_done  (rsp_done),
    .m_active  (m_active),
    .m_strobe  (m_strobe),
    .m_write   (m_write),
    .m_addr    (m_addr),
    .m_wdata   (m_wdata),
    .m_sel     (m_sel),
    .s_ack     (s_ack)
);

// File: tb/bus_single_master_bench.sv
module bus_single_master_bench;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int SW = DW / 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          cmd_start, cmd_write;
    logic [AW-1:0] cmd_addr;
    logic [DW-1:0] cmd_wdata;
    logic [SW-1:0] cmd_sel;
    logic          cmd_busy, rsp_done;
    logic [DW-1:0] rsp_rdata;
    logic          m_active, m_strobe, m_write;
    logic [AW-1:0] m_addr;
    logic [DW-1:0] m_wdata;
    logic [SW-1:0] m_sel;
    logic          s_ack;
    logic [DW-1:0] s_rdata;

    int tests = 0;
    int fails = 0;
    bit finished = 0;
    logic [DW-1:0] exp_rd = '0;

    always #5 clk = ~clk;

    bus_single_master #(.ADDR_W(AW), .DATA_W(DW)) u_bus_single_master (
        .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_sel(cmd_sel),
        .cmd_busy(cmd_busy), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .m_active(m_active), .m_strobe(m_strobe), .m_write(m_write),
        .m_addr(m_addr), .m_wdata(m_wdata), .m_sel(m_sel),
        .s_ack(s_ack), .s_rdata(s_rdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit is_idle();
        return !m_active && !m_strobe && !m_write && !cmd_busy && m_sel == '0;
    endfunction

    task automatic check_idle(input string tag);
        chk(is_idle(), tag, {m_active, m_strobe, m_write, cmd_busy, m_sel}, 64'h0);
    endtask

    task automatic run_txn(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                           input logic [SW-1:0] m, input int waits, input bit poke);
        logic [DW-1:0] rd;
        @(negedge clk);
        cmd_write = wr; cmd_addr = a; cmd_wdata = wd; cmd_sel = m; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        chk(m_active && m_strobe && cmd_busy, "R2 open", {m_active, m_strobe, cmd_busy}, 64'h7);
        chk(m_addr == a && m_write == wr, "R2 addr/dir", {m_addr, 31'b0, m_write}, {a, 31'b0, wr});
        chk(m_sel == m, "R10 lanes", m_sel, m);
        if (wr) chk(m_wdata == wd, "R2 wdata", m_wdata, wd);
        for (int i = 0; i < waits; i++) begin
            if (poke && i == 0) begin
                cmd_start = 1'b1; cmd_addr = ~a; cmd_write = ~wr; cmd_sel = ~m;
            end
            @(negedge clk);
            cmd_start = 1'b0;
            chk(m_active && m_addr == a && m_write == wr && m_sel == m,
                poke ? "R7 ignored start" : "R3 wait hold", m_addr, a);
        end
        rd = $urandom;
        s_rdata = rd; s_ack = 1'b1;
        @(negedge clk);
        s_ack = 1'b0; s_rdata = $urandom;
        if (!wr) exp_rd = rd;
        chk(rsp_done == 1'b1, "R4 done", rsp_done, 1);
        check_idle("R4 close");
        chk(rsp_rdata == exp_rd, wr ? "R6 write keeps rdata" : "R5 read capture", rsp_rdata, exp_rd);
        @(negedge clk);
        chk(rsp_done == 1'b0, "R4 single pulse", rsp_done, 0);
        check_idle("R7 no extra cycle");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog expired (all R) actual=hung expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cmd_start = 1'b0; cmd_write = 1'b0; cmd_addr = '0;
        cmd_wdata = '0; cmd_sel = '0; s_ack = 1'b0; s_rdata = '0;
        void'($urandom(32'd12345));
        // R1: reset held, start and ack ignored
        repeat (2) @(negedge clk);
        cmd_start = 1'b1; s_ack = 1'b1;
        @(negedge clk);
        check_idle("R1 reset idle");
        chk(!rsp_done && rsp_rdata == '0, "R1 reset rsp", {rsp_done, rsp_rdata}, 0);
        cmd_start = 1'b0; s_ack = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        check_idle("R1 idle after release");
        chk($bits(m_sel) == SW, "R10 mask width", $bits(m_sel), SW);

        // R9: stray ack while idle
        s_ack = 1'b1; s_rdata = 32'hDEAD_BEEF;
        @(negedge clk);
        s_ack = 1'b0;
        chk(!rsp_done && rsp_rdata == exp_rd, "R9 stray ack", {rsp_done, rsp_rdata}, {1'b0, exp_rd});
        check_idle("R9 no cycle");

        // directed corners
        run_txn(1'b0, 32'h0000_0010, 32'h0, 4'b1111, 0, 0);
        run_txn(1'b1, 32'hFFFF_FFFC, 32'hA5A5_5A5A, 4'b0001, 0, 0);
        run_txn(1'b1, 32'h1234_5678, 32'h0F0F_F0F0, 4'b1000, 6, 1);
        run_txn(1'b0, 32'h8000_0000, 32'h0, 4'b0110, 9, 1);

        // R8: reset in the middle of a cycle
        @(negedge clk);
        cmd_write = 1'b0; cmd_addr = 32'h55; cmd_sel = 4'hF; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        chk(m_active, "R8 cycle open", m_active, 1);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check_idle("R8 abort");
        chk(!rsp_done, "R8 no done", rsp_done, 0);
        s_ack = 1'b1;
        @(negedge clk);
        rst = 1'b0; s_ack = 1'b0;
        exp_rd = '0;
        @(negedge clk);
        chk(!rsp_done && rsp_rdata == '0, "R8 no done after release", {rsp_done, rsp_rdata}, 0);
        check_idle("R1 idle after abort");

        // random mix
        for (int n = 0; n < 200; n++) begin
            run_txn(1'($urandom), $urandom, $urandom, 4'($urandom), int'($urandom % 7), 1'($urandom));
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule